// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block is a single bank of 32 level-sensitive interrupt lines placed in front of two processors, a main CPU and a coprocessor. Each target has its own per-line enable mask and its own per-line class mask. The class mask sends every enabled, pending line either to that target's normal interrupt output or to its fast interrupt output. A software force register can make any line pending with no activity on its input wire. Software can use this to re-raise an interrupt it has already taken, or to test the routing.

Software reaches the bank through a simple word-addressed register port: one 4-bit word address, a write strobe, write data and combinational read data. The enable and force masks have no direct write path. Each is changed only through a set alias and a clear alias, both with write-one semantics, so a single access can turn on or off any group of lines without a read-modify-write sequence. Writing all ones to a clear alias silences the whole bank in one access, and writing a saved mask to the set alias afterwards restores it. A read-only status word reports the lines that are currently driving the CPU fast interrupt.

The word address is the byte offset divided by four. The byte offsets below are the decoded values.

Top module: `irqbank_ctrl`

## Requirements
- R1: After reset every register reads as zero, and cpu_irq, cpu_fiq, cop_irq, cop_fiq and vfiq_status are all zero.
- R2: A write at byte offset 0x24 sets each CPU enable bit whose written bit is 1. The CPU enable mask reads back at 0x20.
- R3: A write at byte offset 0x28 clears each CPU enable bit whose written bit is 1. On every set or clear alias, a 0 data bit leaves the bit unchanged. Clearing with all ones and then setting a saved mask restores exactly that mask.
- R4: The force mask reads at 0x14, is set bit-wise through 0x18 and is cleared bit-wise through 0x1C. A forced line counts as pending while its input is low.
- R5: The CPU class mask at 0x2C is plain read/write. A 0 bit routes that line to cpu_irq, and a 1 bit routes it to cpu_fiq.
- R6: The coprocessor enable mask reads at 0x30, is set through 0x34 and is cleared through 0x38. Its class mask at 0x3C is plain read/write and routes the line to cop_irq (0) or cop_fiq (1).
- R7: pending = irq_in OR force. Each normal output is the OR over all lines of pending AND enable AND NOT class, and each fast output is the same with class set, using that target's own masks.
- R8: vfiq_status, also readable at byte offset 0x08, has bit n set exactly when line n is pending, CPU-enabled and CPU-classed as fast. Writes to 0x08 change nothing.
- R9: A read at a set or clear alias returns the current value of the mask that alias changes. Any offset not listed reads as zero and ignores writes.
- R10: A write takes effect at the clock edge on which wr_en is sampled high, and the outputs show the new state from that edge onward, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address (byte offset / 4) |
| wr_data | input | 32 | Write data, one bit per line |
| rd_data | output | 32 | Combinational read data for addr |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | CPU normal interrupt |
| cpu_fiq | output | 1 | CPU fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |
| vfiq_status | output | 32 | Lines currently driving the CPU fast interrupt |

## Verification
The hardest case to reach from the ports is a single line whose pending state comes only from the force mask, while the two targets classify it differently. In that case one target's fast output and the other target's normal output must rise together, and every other output must stay low. The bench sweeps all 64 combinations of input level, force, both enables and both classes, on every one of the 32 lines. Before each combination it clears all masks through the aliases, so no state is left over from the previous one. Separate sequences confirm that zero data bits leave their mask bits alone and that a clear-all followed by a saved-mask set restores the mask exactly.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
    localparam int ADDR_W = 4;

    // word addresses; byte offset = word * 4
    typedef enum logic [ADDR_W-1:0] {
        W_VSTAT     = 4'h2,
        W_FRC       = 4'h5,
        W_FRC_SET   = 4'h6,
        W_FRC_CLR   = 4'h7,
        W_CPU_EN    = 4'h8,
        W_CPU_SET   = 4'h9,
        W_CPU_CLR   = 4'hA,
        W_CPU_CLASS = 4'hB,
        W_COP_EN    = 4'hC,
        W_COP_SET   = 4'hD,
        W_COP_CLR   = 4'hE,
        W_COP_CLASS = 4'hF
    } reg_word_e;

    localparam int N_TARGETS = 2;
    localparam int TGT_CPU   = 0;
    localparam int TGT_COP   = 1;
endpackage

// File: rtl/irqbank_setclr.sv
module irqbank_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (set_stb) q <= q | data;
        else if (clr_stb) q <= q & ~data;
    end

    // used for the CPU enable (R2/R3), force (R4) and coprocessor enable (R6) masks
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(data)) == $past(data)));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((q & $past(data)) == '0));
    assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> (((q ^ $past(q)) & ~$past(data)) == '0));
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_stb || clr_stb) |=> $stable(q));
endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
    import irqbank_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wr_data,
    output logic [LINES-1:0]  frc_q,
    output logic [LINES-1:0]  cpu_en_q,
    output logic [LINES-1:0]  cpu_cls_q,
    output logic [LINES-1:0]  cop_en_q,
    output logic [LINES-1:0]  cop_cls_q
);
    logic hit_frc_set, hit_frc_clr, hit_cpu_set, hit_cpu_clr;
    logic hit_cop_set, hit_cop_clr, hit_cpu_cls, hit_cop_cls;

    always_comb begin
        hit_frc_set = wr_en && (addr == W_FRC_SET);
        hit_frc_clr = wr_en && (addr == W_FRC_CLR);
        hit_cpu_set = wr_en && (addr == W_CPU_SET);
        hit_cpu_clr = wr_en && (addr == W_CPU_CLR);
        hit_cop_set = wr_en && (addr == W_COP_SET);
        hit_cop_clr = wr_en && (addr == W_COP_CLR);
        hit_cpu_cls = wr_en && (addr == W_CPU_CLASS);
        hit_cop_cls = wr_en && (addr == W_COP_CLASS);
    end

    irqbank_setclr #(.W(LINES)) u_frc (
        .clk(clk), .rst_n(rst_n), .set_stb(hit_frc_set), .clr_stb(hit_frc_clr),
        .data(wr_data), .q(frc_q));
    irqbank_setclr #(.W(LINES)) u_cpu_en (
        .clk(clk), .rst_n(rst_n), .set_stb(hit_cpu_set), .clr_stb(hit_cpu_clr),
        .data(wr_data), .q(cpu_en_q));
    irqbank_setclr #(.W(LINES)) u_cop_en (
        .clk(clk), .rst_n(rst_n), .set_stb(hit_cop_set), .clr_stb(hit_cop_clr),
        .data(wr_data), .q(cop_en_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_cls_q <= '0;
            cop_cls_q <= '0;
        end else begin
            if (hit_cpu_cls) cpu_cls_q <= wr_data;
            if (hit_cop_cls) cop_cls_q <= wr_data;
        end
    end

    assert_class_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cpu_cls |=> (cpu_cls_q == $past(wr_data)));
    assert_cop_class_rw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cop_cls |=> (cop_cls_q == $past(wr_data)));
    assert_other_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr < W_FRC || addr == W_CPU_EN || addr == W_COP_EN || addr == W_FRC))
        |=> ($stable(frc_q) && $stable(cpu_en_q) && $stable(cpu_cls_q)
             && $stable(cop_en_q) && $stable(cop_cls_q)));
endmodule

// File: rtl/irqbank_route.sv
module irqbank_route #(
    parameter int LINES = 32
) (
    input  logic [LINES-1:0] pending,
    input  logic [LINES-1:0] en,
    input  logic [LINES-1:0] cls,
    output logic [LINES-1:0] fast_lines,
    output logic             norm_out,
    output logic             fast_out
);
    logic [LINES-1:0] live;

    always_comb begin
        live       = pending & en;
        fast_lines = live & cls;
        norm_out   = |(live & ~cls);
        fast_out   = |fast_lines;
    end
endmodule

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
    import irqbank_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wr_data,
    output logic [LINES-1:0]  rd_data,
    input  logic [LINES-1:0]  irq_in,
    output logic              cpu_irq,
    output logic              cpu_fiq,
    output logic              cop_irq,
    output logic              cop_fiq,
    output logic [LINES-1:0]  vfiq_status
);
    logic [LINES-1:0] frc_q, cpu_en_q, cpu_cls_q, cop_en_q, cop_cls_q;
    logic [LINES-1:0] pending;
    logic [N_TARGETS-1:0][LINES-1:0] t_en, t_cls, t_fast;
    logic [N_TARGETS-1:0] t_norm, t_fiq;

    irqbank_regs #(.LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .frc_q(frc_q), .cpu_en_q(cpu_en_q), .cpu_cls_q(cpu_cls_q),
        .cop_en_q(cop_en_q), .cop_cls_q(cop_cls_q));

    always_comb begin
        pending        = irq_in | frc_q;
        t_en[TGT_CPU]  = cpu_en_q;
        t_cls[TGT_CPU] = cpu_cls_q;
        t_en[TGT_COP]  = cop_en_q;
        t_cls[TGT_COP] = cop_cls_q;
    end

    for (genvar t = 0; t < N_TARGETS; t++) begin : g_tgt
        irqbank_route #(.LINES(LINES)) u_route (
            .pending(pending), .en(t_en[t]), .cls(t_cls[t]),
            .fast_lines(t_fast[t]), .norm_out(t_norm[t]), .fast_out(t_fiq[t]));
    end

    always_comb begin
        cpu_irq     = t_norm[TGT_CPU];
        cpu_fiq     = t_fiq[TGT_CPU];
        cop_irq     = t_norm[TGT_COP];
        cop_fiq     = t_fiq[TGT_COP];
        vfiq_status = t_fast[TGT_CPU];
    end

    always_comb begin
        unique case (addr)
            W_VSTAT:                         rd_data = t_fast[TGT_CPU];
            W_FRC, W_FRC_SET, W_FRC_CLR:     rd_data = frc_q;
            W_CPU_EN, W_CPU_SET, W_CPU_CLR:  rd_data = cpu_en_q;
            W_CPU_CLASS:                     rd_data = cpu_cls_q;
            W_COP_EN, W_COP_SET, W_COP_CLR:  rd_data = cop_en_q;
            W_COP_CLASS:                     rd_data = cop_cls_q;
            default:                         rd_data = '0;
        endcase
    end

    assert_quiet_cpu_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en_q == '0) |-> (!cpu_irq && !cpu_fiq && vfiq_status == '0));
    assert_quiet_cop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_en_q == '0) |-> (!cop_irq && !cop_fiq));
    assert_status_drives_fiq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vfiq_status != '0) |-> cpu_fiq);
    assert_force_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((frc_q & cpu_en_q & ~cpu_cls_q) != '0) |-> cpu_irq);
endmodule

// File: tb/irqbank_ctrl_tb.sv
module irqbank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] irq_in = '0;
    logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;
    logic [31:0] vfiq_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqbank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_in(irq_in), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
        .cop_irq(cop_irq), .cop_fiq(cop_fiq), .vfiq_status(vfiq_status));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    logic [31:0] v;
    logic [31:0] saved;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 unmapped read zero
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 outputs", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
        chk("R1 status", vfiq_status, 32'h0);

        // R2 set alias
        wr(4'h9, 32'hA5A5_0000);
        rd(4'h8, v); chk("R2 set", v, 32'hA5A5_0000);
        wr(4'h9, 32'h0000_00F0);
        rd(4'h8, v); chk("R2 set or", v, 32'hA5A5_00F0);
        // R9 alias readback
        rd(4'h9, v); chk("R9 set alias read", v, 32'hA5A5_00F0);
        rd(4'hA, v); chk("R9 clr alias read", v, 32'hA5A5_00F0);

        // R3 clear alias, zero bits untouched, restore
        wr(4'hA, 32'h0505_0030);
        rd(4'h8, v); chk("R3 clear", v, 32'hA0A0_00C0);
        saved = v;
        wr(4'hA, 32'hFFFF_FFFF);
        rd(4'h8, v); chk("R3 clear all", v, 32'h0);
        wr(4'h9, saved);
        rd(4'h8, v); chk("R3 restore", v, saved);
        wr(4'hA, 32'hFFFF_FFFF);

        // R9 unmapped write ignored
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h5, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            chk("R9 unmapped write ignored", v, 32'h0);
        end

        // R10 timing: set enable with input high, output changes only at edge
        irq_in = 32'h0000_0008;
        addr = 4'h9; wr_data = 32'h0000_0008; wr_en = 1'b1;
        #1 chk("R10 before edge", {31'h0, cpu_irq}, 32'h0);
        @(posedge clk); #1;
        chk("R10 after edge", {31'h0, cpu_irq}, 32'h1);
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        wr(4'hA, 32'hFFFF_FFFF);
        irq_in = '0;

        // R4 force register
        wr(4'h6, 32'h8000_0001);
        rd(4'h5, v); chk("R4 force set", v, 32'h8000_0001);
        wr(4'h7, 32'h0000_0001);
        rd(4'h7, v); chk("R4 force clr", v, 32'h8000_0000);
        // R8 status with forced line, write to status ignored
        wr(4'hB, 32'h8000_0000);
        wr(4'h9, 32'h8000_0000);
        chk("R8 status", vfiq_status, 32'h8000_0000);
        rd(4'h2, v); chk("R8 status read", v, 32'h8000_0000);
        wr(4'h2, 32'h0);
        rd(4'h2, v); chk("R8 status write ignored", v, 32'h8000_0000);
        chk("R5 class routes fiq", {30'h0, cpu_irq, cpu_fiq}, 32'h1);
        rd(4'hB, v); chk("R5 class read", v, 32'h8000_0000);
        wr(4'hB, 32'h0);
        chk("R5 class routes irq", {30'h0, cpu_irq, cpu_fiq}, 32'h2);
        wr(4'hA, 32'hFFFF_FFFF);
        wr(4'h7, 32'hFFFF_FFFF);

        // R6 COP registers
        wr(4'hD, 32'h1234_5678);
        wr(4'hE, 32'h0000_0078);
        rd(4'hC, v); chk("R6 cop enable", v, 32'h1234_5600);
        wr(4'hF, 32'hCAFE_0000);
        rd(4'hF, v); chk("R6 cop class", v, 32'hCAFE_0000);
        wr(4'hE, 32'hFFFF_FFFF);
        wr(4'hF, 32'h0);

        // R7 sweep: every line, all 64 combinations
        for (int ln = 0; ln < 32; ln++) begin
            for (int c = 0; c < 64; c++) begin
                logic b_in, b_frc, b_cen, b_ccl, b_pen, b_pcl, pend;
                logic [31:0] bit_m;
                b_in  = c[0]; b_frc = c[1]; b_cen = c[2];
                b_ccl = c[3]; b_pen = c[4]; b_pcl = c[5];
                bit_m = 32'h1 << ln;
                wr(4'hA, 32'hFFFF_FFFF);
                wr(4'hE, 32'hFFFF_FFFF);
                wr(4'h7, 32'hFFFF_FFFF);
                wr(4'hB, b_ccl ? bit_m : 32'h0);
                wr(4'hF, b_pcl ? bit_m : 32'h0);
                if (b_frc) wr(4'h6, bit_m);
                if (b_cen) wr(4'h9, bit_m);
                if (b_pen) wr(4'hD, bit_m);
                irq_in = b_in ? bit_m : 32'h0;
                #1;
                pend = b_in | b_frc;
                chk("R7 sweep outputs", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq},
                    {28'h0, pend & b_cen & ~b_ccl, pend & b_cen & b_ccl,
                     pend & b_pen & ~b_pcl, pend & b_pen & b_pcl});
                chk("R8 sweep status", vfiq_status,
                    (pend & b_cen & b_ccl) ? bit_m : 32'h0);
                @(negedge clk);
            end
        end
        irq_in = '0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule